// File: doc/BRIEF.md
# Host Register Access Port

This block lets a host processor read and write a small bank of byte-wide internal registers. The host drives an active-low chip select, a register address, an address strobe and separate active-low read and write strobes. All of these are asynchronous to the internal clock. The block answers with an active-low acknowledge, and the host stays in wait states until that acknowledge arrives.

The register address comes from a sampled latch. While the address strobe is high and the port is selected, the latch follows the address pins. Once the strobe falls, the latch holds its value. Read data goes out on the low byte of the host bus while a read is in progress. The high byte is never enabled, so it floats. A write is committed to the register file once the synchronised write strobe has been seen to end. A side readback port lets test logic see any register at any time.

While the `dma_busy` input is high, the host side is treated as deselected.

Top module: `sra_host_port`

## Requirements
- R1: While `cs_n` is high, the address pins and the address strobe have no effect on the latched register address.
- R2: While the port is selected and `addr_stb` is high, the latched address follows `reg_addr` on every clock. After `addr_stb` falls, the latched address holds even if the pins change.
- R3: When a write strobe ends, the byte present on `bus_in` during the write is stored into the latched register, within SYNC_STAGES+2 clocks of `wr_n` rising. Every other register keeps its value.
- R4: `bus_oe_lo` is high exactly while `cs_n`, `rd_n` and `dma_busy` are all low. During that time, `bus_out` carries the content of the latched register.
- R5: `bus_oe_hi` stays low at all times, so the upper byte of the bus is never driven.
- R6: After a strobe becomes active with the port selected, `ack_n` goes low exactly SYNC_STAGES+ACK_DELAY clock edges later (4 with the defaults) and stays low while the strobe is held.
- R7: `ack_n` returns high in the same cycle as the strobe, or the chip select, deasserts, with no clock edge needed.
- R8: While `dma_busy` is high, strobes produce no acknowledge, no bus drive and no register write.
- R9: After reset, every register reads 0, `ack_n` is high and both bus enables are low.
- R10: `tst_data` always shows the content of register `tst_addr`, without needing a host access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_busy | input | 1 | High while the bus is mastered internally; host side ignored |
| cs_n | input | 1 | Active-low chip select |
| addr_stb | input | 1 | Address strobe: high = follow the pins, low = hold |
| reg_addr | input | 4 | Register address pins |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_in | input | 8 | Low byte of the host bus, as received |
| bus_out | output | 8 | Read data for the low byte of the host bus |
| bus_oe_lo | output | 1 | Output enable for the low byte |
| bus_oe_hi | output | 1 | Output enable for the high byte (always low) |
| ack_n | output | 1 | Active-low acknowledge, ends host wait states |
| tst_addr | input | 4 | Test readback register select |
| tst_data | output | 8 | Test readback data |

## Verification
The assertions assume the host obeys a simple cycle discipline:
- `cs_n` stays low for the whole data phase of an access.
- Read and write strobes are never low at the same time.
- The address, `bus_in` and `dma_busy` stay stable from the strobe falling until a few clocks after it rises.
- Accesses are spaced far enough apart that the synchronisers return to idle between them.

The bench drives every input on the falling clock edge. It releases each strobe only after the acknowledge has been seen. It then holds data and chip select for four more clocks and idles before the next access. This keeps every commit and every acknowledge inside the window the assertions expect.

// File: rtl/sra_pkg.sv
package sra_pkg;
   // synchronised strobe pair carried between the front end and control
   typedef struct packed {
      logic rd;
      logic wr;
   } sra_strobe_t;

   localparam int SRA_STROBE_W = 2;
endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "sra_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $fatal(1, "sra_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sra_addr_latch.sv
module sra_addr_latch #(
   parameter int ADDR_W   = 4,
   parameter bit LATCH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              addr_stb,
   input  logic [ADDR_W-1:0] addr_pins,
   output logic [ADDR_W-1:0] addr_q
);
   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 8) else $fatal(1, "sra_addr_latch: ADDR_W out of range");
   end

   logic load;

   generate
      if (LATCH_EN) begin : g_strobed
         // follow while strobe high, freeze once it falls
         assign load = sel && addr_stb;
      end else begin : g_direct
         assign load = sel;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    addr_q <= '0;
      else if (load) addr_q <= addr_pins;
   end

   // R1: deselected port never moves the latched address
   a_r1_hold_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(addr_q));

   generate
      if (LATCH_EN) begin : g_chk
         // R2: strobe low holds the address
         a_r2_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            !addr_stb |=> $stable(addr_q));
      end
   endgenerate
endmodule

// File: rtl/sra_regfile.sv
module sra_regfile #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0] taddr,
   output logic [DATA_W-1:0] tdata
);
   initial begin
      assert (DEPTH == (1 << ADDR_W)) else $fatal(1, "sra_regfile: DEPTH must equal 2**ADDR_W");
      assert (DATA_W >= 1) else $fatal(1, "sra_regfile: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[i] <= '0;
            else if (we && (waddr == ADDR_W'(i)))
               mem[i] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];
   assign tdata = mem[taddr];

   // R3: a write lands in the addressed row on the next edge
   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (taddr == waddr) && $stable(taddr)) |=> (tdata == $past(wdata)));
endmodule

// File: rtl/sra_ack_gen.sv
module sra_ack_gen #(
   parameter int ACK_DELAY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strb_s,
   input  logic raw_act,
   output logic ack_n
);
   localparam int CW = $clog2(ACK_DELAY + 1) + 1;
   localparam logic [CW-1:0] CNT_MAX = CW'(ACK_DELAY);

   initial begin
      assert (ACK_DELAY >= 1) else $fatal(1, "sra_ack_gen: ACK_DELAY must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!strb_s)         cnt <= '0;
      else if (cnt != CNT_MAX)  cnt <= cnt + 1'b1;
   end

   assign ack_q = (cnt == CNT_MAX);
   // release is combinational on the raw strobe
   assign ack_n = !(ack_q && raw_act);

   // R6: acknowledge only rises after the synchronised strobe was present
   a_r6_ack_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> $past(strb_s));
endmodule

// File: rtl/sra_host_port.sv
module sra_host_port
   import sra_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ACK_DELAY   = 2,
   parameter bit ADDR_LATCH  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_busy,
   input  logic              cs_n,
   input  logic              addr_stb,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe_lo,
   output logic              bus_oe_hi,
   output logic              ack_n,
   input  logic [ADDR_W-1:0] tst_addr,
   output logic [DATA_W-1:0] tst_data
);
   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (SYNC_STAGES >= 2) else $fatal(1, "sra_host_port: SYNC_STAGES must be at least 2");
      assert (ACK_DELAY >= 1) else $fatal(1, "sra_host_port: ACK_DELAY must be at least 1");
   end

   logic        sel;
   sra_strobe_t raw, syn;
   logic        wr_s_d;
   logic        commit;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] stage_addr;
   logic [DATA_W-1:0] stage_data;
   logic [DATA_W-1:0] rd_data;

   assign sel    = !cs_n && !dma_busy;
   assign raw.rd = sel && !rd_n;
   assign raw.wr = sel && !wr_n;

   sra_sync #(.STAGES(SYNC_STAGES), .WIDTH(SRA_STROBE_W)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw),
      .q_sync  (syn)
   );

   sra_addr_latch #(.ADDR_W(ADDR_W), .LATCH_EN(ADDR_LATCH)) u_alat (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .addr_stb  (addr_stb),
      .addr_pins (reg_addr),
      .addr_q    (addr_q)
   );

   // staging follows the bus while the synchronised write is active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_s_d     <= 1'b0;
         stage_addr <= '0;
         stage_data <= '0;
      end else begin
         wr_s_d <= syn.wr;
         if (syn.wr) begin
            stage_addr <= addr_q;
            stage_data <= bus_in;
         end
      end
   end

   assign commit = wr_s_d && !syn.wr;

   sra_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (commit),
      .waddr (stage_addr),
      .wdata (stage_data),
      .raddr (addr_q),
      .rdata (rd_data),
      .taddr (tst_addr),
      .tdata (tst_data)
   );

   sra_ack_gen #(.ACK_DELAY(ACK_DELAY)) u_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .strb_s  (syn.rd || syn.wr),
      .raw_act (raw.rd || raw.wr),
      .ack_n   (ack_n)
   );

   assign bus_out   = rd_data;
   assign bus_oe_lo = raw.rd;
   assign bus_oe_hi = 1'b0;

   // R4: low byte driven only inside a selected read
   a_r4_oe_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe_lo |-> (!cs_n && !rd_n && !dma_busy));
   // R7: no acknowledge without an active strobe
   a_r7_ack_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && wr_n) |-> ack_n);
   // R8: internal mastership blocks the acknowledge
   a_r8_no_ack_in_dma: assert property (@(posedge clk) disable iff (!rst_n)
      dma_busy |-> ack_n);
   // R3: a commit is a single-cycle pulse
   a_r3_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);
endmodule

// File: tb/sra_host_port_tb_top.sv
module sra_host_port_tb_top;
   localparam int SYNC = 2;
   localparam int ADLY = 2;
   localparam int LAT  = SYNC + ADLY;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dma_busy = 1'b0;
   logic       cs_n = 1'b1;
   logic       addr_stb = 1'b0;
   logic [3:0] reg_addr = '0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] bus_in = '0;
   logic [7:0] bus_out;
   logic       bus_oe_lo, bus_oe_hi, ack_n;
   logic [3:0] tst_addr = '0;
   logic [7:0] tst_data;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] model [16];

   always #2 clk = ~clk;

   sra_host_port #(.SYNC_STAGES(SYNC), .ACK_DELAY(ADLY)) dut_i (
      .clk(clk), .rst_n(rst_n), .dma_busy(dma_busy), .cs_n(cs_n),
      .addr_stb(addr_stb), .reg_addr(reg_addr), .rd_n(rd_n), .wr_n(wr_n),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe_lo(bus_oe_lo),
      .bus_oe_hi(bus_oe_hi), .ack_n(ack_n), .tst_addr(tst_addr), .tst_data(tst_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int i, input int salt);
      return 8'((i * 37 + salt * 11 + 5) & 8'hFF);
   endfunction

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wait_ack(input string req);
      int n = 0;
      while (ack_n && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(n == LAT, req, n, LAT);
   endtask

   task automatic check_all_regs(input string req);
      for (int r = 0; r < 16; r++) begin
         tst_addr = 4'(r);
         #1;
         chk(tst_data == model[r], req, tst_data, model[r]);
      end
   endtask

   task automatic host_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = 0; addr_stb = 1; reg_addr = a;
      @(negedge clk);
      addr_stb = 0; reg_addr = ~a; bus_in = d; wr_n = 0;
      wait_ack("R6 write ack latency");
      idle(2);
      chk(ack_n == 1'b0, "R6 ack held", ack_n, 0);
      wr_n = 1;
      #1;
      chk(ack_n == 1'b1, "R7 ack release on write end", ack_n, 1);
      idle(4);
      cs_n = 1; bus_in = 8'h00;
      model[a] = d;
      idle(3);
   endtask

   task automatic host_read(input logic [3:0] a);
      @(negedge clk);
      cs_n = 0; addr_stb = 1; reg_addr = a;
      @(negedge clk);
      addr_stb = 0; reg_addr = ~a; rd_n = 0;
      #1;
      chk(bus_oe_lo == 1'b1, "R4 oe during read", bus_oe_lo, 1);
      chk(bus_out == model[a], "R4 read data", bus_out, model[a]);
      chk(bus_oe_hi == 1'b0, "R5 high byte floats", bus_oe_hi, 0);
      wait_ack("R6 read ack latency");
      rd_n = 1;
      #1;
      chk(ack_n == 1'b1, "R7 ack release on read end", ack_n, 1);
      chk(bus_oe_lo == 1'b0, "R4 oe off after read", bus_oe_lo, 0);
      @(negedge clk);
      cs_n = 1;
      idle(4);
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int r = 0; r < 16; r++) model[r] = 8'h00;
      idle(3);
      // R9 reset state
      chk(ack_n == 1'b1, "R9 ack idle", ack_n, 1);
      chk(bus_oe_lo == 1'b0, "R9 oe_lo idle", bus_oe_lo, 0);
      chk(bus_oe_hi == 1'b0, "R9 oe_hi idle", bus_oe_hi, 0);
      check_all_regs("R9 reset contents");
      rst_n = 1;
      idle(2);

      // R3 / R10: sweep writes, check whole file via test port each time
      for (int i = 0; i < 16; i++) begin
         host_write(4'(i), pat(i, 0));
         check_all_regs("R3 R10 write sweep");
      end
      // overwrite in reverse order with a second pattern
      for (int i = 15; i >= 0; i -= 3) host_write(4'(i), pat(i, 7));
      check_all_regs("R3 rewrite");

      // R4 / R6: read sweep
      for (int i = 0; i < 16; i++) host_read(4'(i));

      // R2: transparent while strobe high, then held
      @(negedge clk);
      cs_n = 0; addr_stb = 1; reg_addr = 4'd5; rd_n = 0;
      @(negedge clk);
      chk(bus_out == model[5], "R2 flow first", bus_out, model[5]);
      reg_addr = 4'd6;
      @(negedge clk);
      chk(bus_out == model[6], "R2 flow follows", bus_out, model[6]);
      addr_stb = 0;
      @(negedge clk);
      reg_addr = 4'd1;
      idle(2);
      chk(bus_out == model[6], "R2 held after strobe", bus_out, model[6]);
      rd_n = 1;
      @(negedge clk);
      cs_n = 1;
      idle(4);

      // R1: deselected address activity ignored
      @(negedge clk);
      cs_n = 0; addr_stb = 1; reg_addr = 4'd3;
      @(negedge clk);
      addr_stb = 0; cs_n = 1;
      @(negedge clk);
      addr_stb = 1; reg_addr = 4'd9;
      idle(3);
      addr_stb = 0;
      @(negedge clk);
      cs_n = 0; rd_n = 0;
      #1;
      chk(bus_out == model[3], "R1 address ignored while deselected", bus_out, model[3]);
      rd_n = 1;
      @(negedge clk);
      cs_n = 1;
      idle(4);

      // R8: internal mastership blocks everything
      @(negedge clk);
      dma_busy = 1; cs_n = 0; addr_stb = 1; reg_addr = 4'd7;
      @(negedge clk);
      addr_stb = 0; bus_in = 8'hA5; wr_n = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (k == 9) chk(ack_n == 1'b1, "R8 no ack during dma", ack_n, 1);
      end
      wr_n = 1; rd_n = 0;
      #1;
      chk(bus_oe_lo == 1'b0, "R8 no drive during dma", bus_oe_lo, 0);
      rd_n = 1;
      idle(6);
      cs_n = 1; dma_busy = 0;
      idle(2);
      check_all_regs("R8 no write during dma");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule